// File: doc/BRIEF.md
# Variable-Block Carry-Skip Adder

This block adds two unsigned operands and a carry-in and returns the sum and the carry-out. It has no clock and no state. The operand width is split into skip blocks. Each block adds its bits with a short ripple chain of full-adder cells. At the same time, a block-wide propagate term is formed as the AND of the per-bit XOR terms. A two-way multiplexer picks the block's carry-out from these. When every bit of the block propagates, the incoming carry passes straight through. Otherwise the ripple chain's own carry is used.

Block widths come from a parameter list, counted from the least significant end. The default is 16 bits in blocks of 2, 3, 5, 4 and 2. The narrow end blocks shorten the two ripple segments that lie on the worst-case path. The wide middle blocks are crossed by their multiplexers alone. The block has no streaming data, so there is no valid/ready handshake. Operands are applied directly and the result is read once the logic settles.

Top module: `csk_adder`

## Requirements
- R1: For every operand pair and carry-in, {cout_o, sum_o} equals a_i + b_i + cin_i, taken as an unsigned WIDTH+1-bit value.
- R2: With a_i all ones, b_i zero and cin_i = 1, sum_o is all zeros and cout_o is 1.
- R3: With a_i, b_i and cin_i all zero, sum_o is all zeros and cout_o is 0.
- R4: When a_i XOR b_i is all ones, every block skips. Then sum_o is all bits equal to NOT cin_i, and cout_o equals cin_i.
- R5: A carry generated in the least significant block crosses every fully propagating block above it. With a_i = 1, b_i all ones and cin_i = 0, the result is sum_o = 0 and cout_o = 1.
- R6: The default layout is blocks of 2, 3, 5, 4 and 2 bits, starting at bit offsets 0, 2, 5, 10 and 14. A carry entering any single block k whose bits all propagate leaves it unchanged, and that block's sum bits are all zero.
- R7: The block widths must add up to WIDTH. Any other configuration is rejected at elaboration.
- R8: Outputs are a pure function of the present inputs. A result depends on no earlier operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the most significant block |

## Verification
A wrong skip decision inside one block shows at once as a carry error. The carry entering the next block is wrong, so every sum bit above that point that propagates is inverted, and cout_o can be wrong as well. Because the logic has no state, the fault appears in the same evaluation that applies the operands and disappears when they change. The directed patterns aim a carry at each block boundary in turn. The random pairs cover the mixed cases.

// File: rtl/csk_pkg.sv
package csk_pkg;

  // Per-bit propagate/generate pair
  typedef struct packed {
    logic prop;
    logic gen;
  } pg_t;

  // Majority of three inputs, used as an independent carry reference
  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/csk_bit_cell.sv
module csk_bit_cell
  import csk_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output pg_t  pg_o,
  output logic s_o,
  output logic c_o
);

  always_comb begin
    pg_o.prop = a_i ^ b_i;
    pg_o.gen  = a_i & b_i;
    s_o       = pg_o.prop ^ c_i;
    c_o       = pg_o.gen | (pg_o.prop & c_i);
  end

  // R1
  always_comb begin
    cell_carry_chk : assert (c_o == maj3(a_i, b_i, c_i))
      else $error("bit cell carry mismatch");
  end

endmodule

// File: rtl/csk_ripple.sv
module csk_ripple
  import csk_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] p_o,
  output logic         c_o
);

  logic [W:0] chain;
  pg_t  [W-1:0] pg;

  assign chain[0] = c_i;

  for (genvar i = 0; i < W; i++) begin : g_cell
    csk_bit_cell u_cell (
      .a_i (a_i[i]),
      .b_i (b_i[i]),
      .c_i (chain[i]),
      .pg_o(pg[i]),
      .s_o (s_o[i]),
      .c_o (chain[i+1])
    );
    assign p_o[i] = pg[i].prop;
  end

  assign c_o = chain[W];

endmodule

// File: rtl/csk_skip_block.sv
module csk_skip_block #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);

  logic [W-1:0] p_bits;
  logic         rip_c;
  logic         blk_prop;

  csk_ripple #(.W(W)) u_rip (
    .a_i(a_i),
    .b_i(b_i),
    .c_i(c_i),
    .s_o(s_o),
    .p_o(p_bits),
    .c_o(rip_c)
  );

  assign blk_prop = &p_bits;
  assign c_o      = blk_prop ? c_i : rip_c;

  // R4
  always_comb begin
    skip_agree_chk : assert (!blk_prop || (rip_c == c_i))
      else $error("skip taken but ripple carry differs");
  end

  // R6
  always_comb begin
    blk_sum_chk : assert ({c_o, s_o} == ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, c_i}))
      else $error("block result mismatch");
  end

endmodule

// File: rtl/csk_adder.sv
module csk_adder #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned NBLK  = 5,
  parameter int unsigned BLK_W [NBLK] = '{2, 3, 5, 4, 2}
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  function automatic int unsigned blk_off(input int unsigned k);
    int unsigned acc = 0;
    for (int unsigned j = 0; j < k; j++) acc += BLK_W[j];
    return acc;
  endfunction

  localparam int unsigned TOTAL = blk_off(NBLK);

  // R7
  if (TOTAL != WIDTH) begin : g_bad_layout
    $error("block widths do not add up to WIDTH");
  end

  logic [NBLK:0] blk_c;
  assign blk_c[0] = cin_i;

  for (genvar k = 0; k < NBLK; k++) begin : g_blk
    localparam int unsigned OFF = blk_off(k);
    localparam int unsigned BW  = BLK_W[k];
    csk_skip_block #(.W(BW)) u_blk (
      .a_i(a_i[OFF +: BW]),
      .b_i(b_i[OFF +: BW]),
      .c_i(blk_c[k]),
      .s_o(sum_o[OFF +: BW]),
      .c_o(blk_c[k+1])
    );
  end

  assign cout_o = blk_c[NBLK];

  // R1
  always_comb begin
    total_sum_chk : assert ({cout_o, sum_o} ==
                            ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
      else $error("adder result mismatch");
  end

  // R4
  always_comb begin
    all_skip_chk : assert (((a_i ^ b_i) != {WIDTH{1'b1}}) || (cout_o == cin_i))
      else $error("full propagate did not pass carry-in");
  end

endmodule

// File: tb/sim_csk_adder.sv
module sim_csk_adder;

  localparam int W = 16;
  localparam time CLK_PERIOD = 10ns;
  localparam int OFFS [5] = '{0, 2, 5, 10, 14};
  localparam int SIZES [5] = '{2, 3, 5, 4, 2};

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [W-1:0] a, b, s;
  logic cin, cout;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  csk_adder u0 (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(s), .cout_o(cout)
  );

  function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    @(negedge clk);
    a = x; b = y; cin = c;
    #1;
  endtask

  task automatic check(input string req, input logic [W:0] exp);
    n_chk++;
    if ({cout, s} !== exp) begin
      n_err++;
      $display("FAIL %s a=%h b=%h cin=%b got=%h exp=%h", req, a, b, cin, {cout, s}, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R3 all zeros
    apply('0, '0, 1'b0);
    check("R3", {(W+1){1'b0}});
    // R2 all ones plus one via carry-in
    apply('1, '0, 1'b1);
    check("R2", {1'b1, {W{1'b0}}});
    apply('1, 16'd1, 1'b0);
    check("R2", {1'b1, {W{1'b0}}});
    // R4 every block propagates, both carry-in values
    for (int c = 0; c < 2; c++) begin
      apply(16'hA5C3, ~16'hA5C3, c[0]);
      check("R4", {c[0], {W{~c[0]}}});
      apply(16'h0000, 16'hFFFF, c[0]);
      check("R4", {c[0], {W{~c[0]}}});
    end
    // R5 generate at bit 0 skips all the way
    apply(16'd1, '1, 1'b0);
    check("R5", {1'b1, {W{1'b0}}});
    // R6 per-block skip: carry enters block k, block k all propagating
    for (int k = 1; k < 5; k++) begin
      logic [W-1:0] x, y;
      x = '0; y = '0;
      x[OFFS[k]-1] = 1'b1; y[OFFS[k]-1] = 1'b1;
      for (int j = 0; j < SIZES[k]; j++) x[OFFS[k]+j] = 1'b1;
      apply(x, y, 1'b0);
      check("R6", ref_add(x, y, 1'b0));
      if (s[OFFS[k] +: 2] !== 2'b00) begin
        n_chk++; n_err++;
        $display("FAIL R6 block %0d low sum bits got=%b exp=00", k, s[OFFS[k] +: 2]);
      end else n_chk++;
    end
    // R1 both carry-in values on mixed patterns
    for (int c = 0; c < 2; c++) begin
      apply(16'h1234, 16'h8FED, c[0]);
      check("R1", ref_add(16'h1234, 16'h8FED, c[0]));
      apply(16'h7FFF, 16'h0001, c[0]);
      check("R1", ref_add(16'h7FFF, 16'h0001, c[0]));
    end
    // R8 result follows the new inputs only
    apply('1, '1, 1'b1);
    apply(16'd3, 16'd4, 1'b0);
    check("R8", 17'd7);
    // R1 random
    for (int i = 0; i < 10000; i++) begin
      logic [W-1:0] x, y;
      logic c;
      x = W'($urandom); y = W'($urandom); c = 1'($urandom);
      apply(x, y, c);
      check("R1", ref_add(x, y, c));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule